// File: doc/BRIEF.md
# Adaptive-Gain Bang-Bang Fine Tuner

This block closes the last part of a digital frequency loop, where the time-to-digital converter can no longer resolve the oscillator error. On each update strobe it moves the oscillator control word up or down by the current step gain, following a single early/late direction bit from the phase detector. The control word saturates at both ends of its range.

The step gain adapts to the pattern of directions. A reversal means the loop is straddling the reference, so the gain shrinks by one. The first repeat of a direction halves the gain. Further repeats widen the step by an offset value, and the offset grows only as a round counter runs out. A load strobe seeds the control word and the gain, and clears all of the adaptation history. The gain is kept between one and a parameter ceiling.

Top module: `bb_fine_tuner`

## Requirements
- R1: After reset, word_o is 0 and gain_o is 1. The internal offset and round values are both 1, and there is no direction history.
- R2: When load_i is high, on the next clock word_o takes word_init_i and gain_o takes gain_init_i limited to the range 1..GAIN_MAX (0 becomes 1). Offset and round return to 1 and the history is cleared. load_i has priority over update_i.
- R3: When update_i is high and load_i is low, word_o changes by the gain that was current before the edge. It goes up when dir_i=1 and down when dir_i=0. With neither strobe high, word_o and gain_o hold.
- R4: word_o saturates at 2^WORD_W-1 when counting up and at 0 when counting down.
- R5: The first update after a reset or a load leaves the gain unchanged and records the direction.
- R6: An update whose direction differs from the previous one decrements the gain (never below 1). It also clears the repeat tracking, so the next repeat counts as a first repeat.
- R7: The first update that repeats the previous direction halves the gain (never below 1).
- R8: Each further repeat adds the current offset to the gain, saturating at GAIN_MAX.
- R9: Every repeat decrements the round counter. When the round counter reaches 0, the offset increments (saturating at OFS_MAX) and the round counter is reloaded with the new offset.
- R10: gain_o always lies in 1..GAIN_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Seed word and gain, clear adaptation state |
| word_init_i | input | WORD_W | Control word loaded by load_i |
| gain_init_i | input | GAIN_W | Gain loaded by load_i (one converter step in word units) |
| update_i | input | 1 | Update strobe from the phase detector |
| dir_i | input | 1 | 1: raise control word, 0: lower it |
| word_o | output | WORD_W | Oscillator control word |
| gain_o | output | GAIN_W | Current step gain |

## Verification
The assertions assume that load_i, update_i and dir_i are known at every rising edge after reset. They also assume the width relation GAIN_W <= WORD_W and OFS_W <= GAIN_W, which the step and saturation checks rely on. The stimulus changes inputs only on the falling edge and returns both strobes low after each pulse. Every update and load therefore lasts exactly one cycle with a defined direction. The gain ceiling is lowered in the bench so that the saturating growth path is reached within a few updates.

// File: rtl/bbft_pkg.sv
package bbft_pkg;
  typedef enum logic [1:0] {
    EV_SEED    = 2'd0,  // no previous direction
    EV_REV     = 2'd1,  // direction flipped
    EV_HALVE   = 2'd2,  // first repeat
    EV_GROW    = 2'd3   // later repeat
  } ev_e;
endpackage

// File: rtl/bbft_history.sv
module bbft_history
  import bbft_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic dir_i,
  output ev_e  ev_o
);
  logic have_prev_q, prev_dir_q, seen_q;

  always_comb begin
    if (!have_prev_q)          ev_o = EV_SEED;
    else if (dir_i != prev_dir_q) ev_o = EV_REV;
    else if (!seen_q)          ev_o = EV_HALVE;
    else                       ev_o = EV_GROW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_dir_q  <= 1'b0;
      seen_q      <= 1'b0;
    end else if (load_i) begin
      have_prev_q <= 1'b0;
      prev_dir_q  <= 1'b0;
      seen_q      <= 1'b0;
    end else if (step_i) begin
      have_prev_q <= 1'b1;
      prev_dir_q  <= dir_i;
      seen_q      <= (ev_o == EV_HALVE) || (ev_o == EV_GROW);
    end
  end
endmodule

// File: rtl/bbft_cadence.sv
module bbft_cadence
  import bbft_pkg::*;
#(
  parameter int OFS_W   = 4,
  parameter int OFS_MAX = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  ev_e              ev_i,
  output logic [OFS_W-1:0] offset_o
);
  localparam logic [OFS_W-1:0] OMAX = OFS_MAX[OFS_W-1:0];
  localparam logic [OFS_W-1:0] ONE  = OFS_W'(1);

  logic [OFS_W-1:0] offset_q, round_q, offset_inc;
  logic             repeat_ev;

  assign repeat_ev  = (ev_i == EV_HALVE) || (ev_i == EV_GROW);
  assign offset_inc = (offset_q >= OMAX) ? OMAX : offset_q + ONE;
  assign offset_o   = offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q <= ONE;
      round_q  <= ONE;
    end else if (load_i) begin
      offset_q <= ONE;
      round_q  <= ONE;
    end else if (step_i && repeat_ev) begin
      if (round_q <= ONE) begin
        offset_q <= offset_inc;
        round_q  <= offset_inc;
      end else begin
        round_q  <= round_q - ONE;
      end
    end
  end
endmodule

// File: rtl/bbft_gain.sv
module bbft_gain
  import bbft_pkg::*;
#(
  parameter int GAIN_W   = 8,
  parameter int GAIN_MAX = 200,
  parameter int OFS_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [GAIN_W-1:0] gain_init_i,
  input  logic              step_i,
  input  ev_e               ev_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_MAX[GAIN_W-1:0];
  localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(1);

  logic [GAIN_W-1:0] gain_q, gain_nxt, init_lim, half;
  logic [GAIN_W:0]   grow_sum;

  assign init_lim = (gain_init_i == '0) ? ONE :
                    (gain_init_i > GMAX) ? GMAX : gain_init_i;
  assign half     = gain_q >> 1;
  assign grow_sum = {1'b0, gain_q} + (GAIN_W+1)'(offset_i);

  always_comb begin
    unique case (ev_i)
      EV_SEED:  gain_nxt = gain_q;
      EV_REV:   gain_nxt = (gain_q > ONE) ? gain_q - ONE : ONE;
      EV_HALVE: gain_nxt = (half == '0) ? ONE : half;
      EV_GROW:  gain_nxt = (grow_sum > {1'b0, GMAX}) ? GMAX : grow_sum[GAIN_W-1:0];
      default:  gain_nxt = gain_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gain_q <= ONE;
    else if (load_i)  gain_q <= init_lim;
    else if (step_i)  gain_q <= gain_nxt;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/bbft_word.sv
module bbft_word #(
  parameter int WORD_W = 12,
  parameter int GAIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_init_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int SUM_W = WORD_W + 1;

  logic [WORD_W-1:0] word_q, word_nxt;
  logic [SUM_W-1:0]  gain_ext, up_sum;

  assign gain_ext = SUM_W'(gain_i);
  assign up_sum   = {1'b0, word_q} + gain_ext;

  always_comb begin
    if (dir_i)
      word_nxt = up_sum[WORD_W] ? '1 : up_sum[WORD_W-1:0];
    else if (gain_ext > {1'b0, word_q})
      word_nxt = '0;
    else
      word_nxt = word_q - gain_ext[WORD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (load_i)  word_q <= word_init_i;
    else if (step_i)  word_q <= word_nxt;
  end

  assign word_o = word_q;
endmodule

// File: rtl/bb_fine_tuner.sv
module bb_fine_tuner
  import bbft_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int GAIN_W   = 8,
  parameter int GAIN_MAX = 200,
  parameter int OFS_W    = 4,
  parameter int OFS_MAX  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_init_i,
  input  logic [GAIN_W-1:0] gain_init_i,
  input  logic              update_i,
  input  logic              dir_i,
  output logic [WORD_W-1:0] word_o,
  output logic [GAIN_W-1:0] gain_o
);
  logic             step;
  ev_e              ev;
  logic [OFS_W-1:0] offset;
  logic [GAIN_W-1:0] gain;

  assign step = update_i && !load_i;

  bbft_history i_history (
    .clk_i, .rst_ni, .load_i,
    .step_i (step),
    .dir_i,
    .ev_o   (ev)
  );

  bbft_cadence #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX)) i_cadence (
    .clk_i, .rst_ni, .load_i,
    .step_i   (step),
    .ev_i     (ev),
    .offset_o (offset)
  );

  bbft_gain #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .OFS_W(OFS_W)) i_gain (
    .clk_i, .rst_ni, .load_i,
    .gain_init_i,
    .step_i   (step),
    .ev_i     (ev),
    .offset_i (offset),
    .gain_o   (gain)
  );

  bbft_word #(.WORD_W(WORD_W), .GAIN_W(GAIN_W)) i_word (
    .clk_i, .rst_ni, .load_i,
    .word_init_i,
    .step_i (step),
    .dir_i,
    .gain_i (gain),
    .word_o
  );

  assign gain_o = gain;
endmodule

// File: rtl/bbft_checker.sv
module bbft_checker #(
  parameter int WORD_W   = 12,
  parameter int GAIN_W   = 8,
  parameter int GAIN_MAX = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [GAIN_W-1:0] gain_init_i,
  input logic              update_i,
  input logic              dir_i,
  input logic [WORD_W-1:0] word_o,
  input logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GMAX = GAIN_MAX[GAIN_W-1:0];
  localparam logic [GAIN_W-1:0] ONE  = GAIN_W'(1);

  logic [WORD_W-1:0] word_delta;
  logic [WORD_W-1:0] word_prev;
  logic [GAIN_W-1:0] gain_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_prev <= '0;
      gain_prev <= ONE;
    end else begin
      word_prev <= word_o;
      gain_prev <= gain_o;
    end
  end

  assign word_delta = (word_o >= word_prev) ? word_o - word_prev : word_prev - word_o;

  a_r10_gain_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o >= ONE) && (gain_o <= GMAX));

  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !update_i) |=> ($stable(word_o) && $stable(gain_o)));

  a_r3_up_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !load_i && dir_i) |=> (word_o >= $past(word_o)));

  a_r3_down_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !load_i && !dir_i) |=> (word_o <= $past(word_o)));

  a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !load_i) |=> (word_delta <= WORD_W'(gain_prev)));

  a_r2_load_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (gain_o == (($past(gain_init_i) == '0) ? ONE :
                           ($past(gain_init_i) > GMAX) ? GMAX : $past(gain_init_i))));
endmodule

bind bb_fine_tuner bbft_checker #(
  .WORD_W(WORD_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)
) i_bbft_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .gain_init_i(gain_init_i),
  .update_i(update_i), .dir_i(dir_i), .word_o(word_o), .gain_o(gain_o)
);

// File: tb/test_bb_fine_tuner.sv
module test_bb_fine_tuner;
  localparam int WORD_W   = 12;
  localparam int GAIN_W   = 8;
  localparam int GAIN_MAX = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [WORD_W-1:0] word_init_i = '0;
  logic [GAIN_W-1:0] gain_init_i = '0;
  logic              update_i = 1'b0;
  logic              dir_i = 1'b0;
  logic [WORD_W-1:0] word_o;
  logic [GAIN_W-1:0] gain_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bb_fine_tuner #(.WORD_W(WORD_W), .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX),
                  .OFS_W(4), .OFS_MAX(15)) i_bb_fine_tuner (
    .clk_i(clk), .rst_ni, .load_i, .word_init_i, .gain_init_i,
    .update_i, .dir_i, .word_o, .gain_o
  );

  typedef struct packed {
    logic              ld;
    logic              up;
    logic              dir;
    logic [GAIN_W-1:0] g_init;
    logic [WORD_W-1:0] w_init;
    logic [WORD_W-1:0] exp_w;
    logic [GAIN_W-1:0] exp_g;
  } vec_t;

  // R3 R5 R6 R7 R8 R9: seed, repeats, idle, reversals, repeat after reversal
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 1'b0, 8'd8, 12'd1000, 12'd1000, 8'd8},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1008, 8'd8},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1016, 8'd4},
    '{1'b0, 1'b0, 1'b1, 8'd0, 12'd0,    12'd1016, 8'd4},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1020, 8'd6},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1026, 8'd8},
    '{1'b0, 1'b1, 1'b0, 8'd0, 12'd0,    12'd1018, 8'd7},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1025, 8'd6},
    '{1'b0, 1'b1, 1'b0, 8'd0, 12'd0,    12'd1019, 8'd5},
    '{1'b0, 1'b1, 1'b0, 8'd0, 12'd0,    12'd1014, 8'd2},
    '{1'b0, 1'b1, 1'b0, 8'd0, 12'd0,    12'd1012, 8'd5},
    '{1'b0, 1'b1, 1'b1, 8'd0, 12'd0,    12'd1017, 8'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic ld, input logic up, input logic dir,
                       input int g, input int w);
    @(negedge clk);
    load_i      = ld;
    update_i    = up;
    dir_i       = dir;
    gain_init_i = GAIN_W'(g);
    word_init_i = WORD_W'(w);
    @(negedge clk);
    load_i   = 1'b0;
    update_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input int w, input int g);
    chk({req, " word"}, int'(word_o), w);
    chk({req, " gain"}, int'(gain_o), g);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // R5: first update after reset keeps gain 1
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R5 first update", 1, 1);

    for (int i = 0; i < 12; i++) begin
      pulse(VEC[i].ld, VEC[i].up, VEC[i].dir, int'(VEC[i].g_init), int'(VEC[i].w_init));
      expect_out($sformatf("R3/R7/R8 vector %0d", i), int'(VEC[i].exp_w), int'(VEC[i].exp_g));
    end

    // R2: clamping and priority
    pulse(1'b1, 1'b0, 1'b0, 0, 50);
    expect_out("R2 gain 0 clamp", 50, 1);
    pulse(1'b1, 1'b0, 1'b0, 30, 60);
    expect_out("R2 gain max clamp", 60, GAIN_MAX);
    pulse(1'b1, 1'b1, 1'b1, 5, 100);
    expect_out("R2 load priority", 100, 5);

    // R4: saturation
    pulse(1'b1, 1'b0, 1'b0, 10, 4090);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R4 top saturation", 4095, 10);
    pulse(1'b1, 1'b0, 1'b0, 10, 3);
    pulse(1'b0, 1'b1, 1'b0, 0, 0);
    expect_out("R4 bottom saturation", 0, 10);

    // R6: reversal floor at 1
    pulse(1'b1, 1'b0, 1'b0, 1, 500);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    pulse(1'b0, 1'b1, 1'b0, 0, 0);
    expect_out("R6 reversal floor", 500, 1);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R6 reversal floor again", 501, 1);
    // R7: halving floor at 1
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R7 halve floor", 502, 1);

    // R8 R9: growth cadence up to the ceiling
    pulse(1'b1, 1'b0, 1'b0, 20, 2000);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R5 seed", 2020, 20);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R7 halve", 2040, 10);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R8 grow by 2", 2050, 12);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R9 offset still 2", 2062, 14);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R9 offset now 3", 2076, 17);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R8 grow to max", 2093, 20);
    pulse(1'b0, 1'b1, 1'b1, 0, 0);
    expect_out("R10 ceiling hold", 2113, 20);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule